// File: doc/BRIEF.md
# Multicast hash receive filter

This block decides, once per incoming Ethernet frame, whether the frame is kept or dropped, judging it by its six-byte destination address. A frame opens with a one-cycle `frm_start` strobe, after which the destination bytes arrive on `byte_data` qualified by `byte_valid`, first received byte first. The block stores the address and runs a CRC over it. Six bits of that CRC select one entry of a 64-entry hash table, which is how a whole set of multicast groups is admitted with a single 64-bit mask. A frame-end strobe `frm_end` carries the frame length and the result of the frame checksum test, which is computed elsewhere.

The verdict comes from three match sources: a unicast compare against a 48-bit station address, the all-ones broadcast address, and the hash-table hit. Each source has its own enable bit. A frame that matches any enabled source is still dropped if checksum-good frames are required and the checksum flag is low, if short-frame rejection is on and the frame is under 64 bytes, or if the frame is longer than a programmable maximum. The verdict is a single-cycle `verdict_valid` pulse. `verdict_accept` is high during that pulse for a kept frame, and `hash_idx` shows the table index that was used.

The control sequence runs through these states:
- `ST_IDLE` goes to `ST_ADDR` on `frm_start`.
- `ST_ADDR` goes to `ST_HASH` when the sixth byte is taken. It goes straight to `ST_VERDICT` if `frm_end` arrives before the sixth byte (short address).
- `ST_HASH` goes to `ST_WAIT` after the last CRC step.
- `ST_WAIT` goes to `ST_VERDICT` once the frame end has been seen, whether it arrived earlier or arrives in that cycle.
- `ST_VERDICT` returns to `ST_IDLE` after one cycle.

`frm_start` is only honoured in `ST_IDLE`.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `verdict_valid` is low, both hash words and the station address are zero, all five enables are off and the maximum length is 1518. With this state every frame is rejected.
- R2: A write with `cfg_we` high stores `cfg_wdata` as selected by `cfg_sel`: 0 is hash entries 31..0, 1 is hash entries 63..32, 2/3/4 are station bits 15:0 / 31:16 / 47:32, 5 is the enable bits, 6 is the maximum length in its low 16 bits, and 7 is ignored. Enable bit 0 is hash match, 1 is unicast match, 2 is broadcast match, 3 is checksum-good required, and 4 is short-frame rejection.
- R3: The hash index is bits 28:23 of a CRC preset to 0xFFFFFFFF, shifting left with polynomial 0x04C11DB7. The feedback bit is CRC bit 31 XOR the data bit. The input is the six address bytes in arrival order, each from bit 0 to bit 7, with no final inversion. The index is shown on `hash_idx` during the verdict pulse.
- R4: Table entry k sits in word k/32 at bit k mod 32. With the hash enable on, a frame whose index entry is set matches, and a frame whose entry is clear does not.
- R5: With the unicast enable on, a frame matches when received byte i equals station bits 8i+7:8i for all six bytes.
- R6: With the broadcast enable on, a frame whose six address bytes are all 0xFF matches.
- R7: With checksum-good required, a frame whose `frm_crc_ok` is low is rejected whatever it matches.
- R8: With short-frame rejection on, a frame whose `frm_len` is below 64 is rejected. A length of exactly 64 is not short.
- R9: A frame whose `frm_len` exceeds the maximum length is always rejected. A length equal to the maximum is allowed.
- R10: Each frame gets exactly one single-cycle `verdict_valid` pulse after its `frm_end`, and `verdict_accept` is never high outside it. A frame ending before six address bytes gets a reject verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| frm_start | input | 1 | Start-of-frame strobe |
| byte_valid | input | 1 | Destination byte qualifier |
| byte_data | input | 8 | Destination address byte |
| frm_end | input | 1 | End-of-frame strobe |
| frm_len | input | LEN_W | Frame length in bytes, valid with `frm_end` |
| frm_crc_ok | input | 1 | Frame checksum good, valid with `frm_end` |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame kept (only with `verdict_valid`) |
| hash_idx | output | 6 | Hash table index for the frame |

## Verification
The hardest situation to reach from the ports is a hash hit on a chosen table entry, because the index of an address is only known after the CRC. Choosing an address that lands on one particular entry is not direct. The bench draws pseudo-random addresses, predicts each index with its own bit-serial CRC, and keeps drawing until all 64 entries have been hit. For each entry it programs a table holding only that bit, and then a table holding every bit except that one. A second sweep crosses all 32 enable settings with unicast, broadcast, hash-hit and missing addresses, good and bad checksums, and lengths on both sides of the short-frame and maximum-length limits.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_BYTES        = 6;
    localparam int ADDR_BITS         = ADDR_BYTES * 8;
    localparam int HASH_W            = 6;
    localparam int TABLE_ENTRIES     = 1 << HASH_W;
    localparam int CRC_W             = 32;
    localparam int HASH_LSB          = 23;
    localparam int MIN_FRAME         = 64;
    localparam int MAX_FRAME_DEFAULT = 1518;

    localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;

    localparam logic [2:0] SEL_HASH_LO = 3'd0;
    localparam logic [2:0] SEL_HASH_HI = 3'd1;
    localparam logic [2:0] SEL_STA_LO  = 3'd2;
    localparam logic [2:0] SEL_STA_MID = 3'd3;
    localparam logic [2:0] SEL_STA_HI  = 3'd4;
    localparam logic [2:0] SEL_ENABLE  = 3'd5;
    localparam logic [2:0] SEL_MAXLEN  = 3'd6;

    // packed MSB first: hash lands on bit 0
    typedef struct packed {
        logic runt_rej;
        logic crc_req;
        logic bcast;
        logic ucast;
        logic hash;
    } filt_en_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HASH,
        ST_WAIT,
        ST_VERDICT
    } filt_state_t;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [2:0]               sel,
    input  logic [31:0]              wdata,
    output logic [TABLE_ENTRIES-1:0] hash_tbl,
    output logic [ADDR_BITS-1:0]     station,
    output filt_en_t                 en,
    output logic [LEN_W-1:0]         max_len
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_tbl <= '0;
            station  <= '0;
            en       <= '0;
            max_len  <= LEN_W'(MAX_FRAME_DEFAULT);
        end else if (we) begin
            case (sel)
                SEL_HASH_LO: hash_tbl[31:0]  <= wdata;
                SEL_HASH_HI: hash_tbl[63:32] <= wdata;
                SEL_STA_LO:  station[15:0]   <= wdata[15:0];
                SEL_STA_MID: station[31:16]  <= wdata[15:0];
                SEL_STA_HI:  station[47:32]  <= wdata[15:0];
                SEL_ENABLE:  en              <= filt_en_t'(wdata[4:0]);
                SEL_MAXLEN:  max_len         <= wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rxf_hash_crc.sv
module rxf_hash_crc
    import rxf_pkg::*;
#(
    parameter int STEP_BITS = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 preset,
    input  logic                 advance,
    input  logic [STEP_BITS-1:0] din,
    output logic [HASH_W-1:0]    idx
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_nxt;

    generate
        if (STEP_BITS == 1) begin : g_serial
            always_comb begin
                crc_nxt = {crc_q[CRC_W-2:0], 1'b0} ^
                          ((crc_q[CRC_W-1] ^ din[0]) ? CRC_POLY : '0);
            end
        end else begin : g_multi
            // bit 0 of din is consumed first
            always_comb begin
                logic [CRC_W-1:0] c;
                c = crc_q;
                for (int b = 0; b < STEP_BITS; b++) begin
                    c = {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ din[b]) ? CRC_POLY : '0);
                end
                crc_nxt = c;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || preset) begin
            crc_q <= CRC_PRESET;
        end else if (advance) begin
            crc_q <= crc_nxt;
        end
    end

    assign idx = crc_q[HASH_LSB +: HASH_W];

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict
    import rxf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [ADDR_BITS-1:0]     dst,
    input  logic [ADDR_BITS-1:0]     station,
    input  logic [TABLE_ENTRIES-1:0] hash_tbl,
    input  logic [HASH_W-1:0]        idx,
    input  filt_en_t                 en,
    input  logic [LEN_W-1:0]         len,
    input  logic [LEN_W-1:0]         max_len,
    input  logic                     crc_ok,
    input  logic                     short_addr,
    output logic                     accept
);

    logic uc_hit, bc_hit, hash_hit, any_hit;
    logic bad_crc, runt, too_long;

    always_comb begin
        uc_hit   = en.ucast && (dst == station);
        bc_hit   = en.bcast && (&dst);
        hash_hit = en.hash && hash_tbl[idx];
        any_hit  = uc_hit || bc_hit || hash_hit;
        bad_crc  = en.crc_req && !crc_ok;
        runt     = en.runt_rej && (len < LEN_W'(MIN_FRAME));
        too_long = len > max_len;
        accept   = any_hit && !bad_crc && !runt && !too_long && !short_addr;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int STEP_BITS = 1,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             frm_start,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             frm_end,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_crc_ok,
    output logic             verdict_valid,
    output logic             verdict_accept,
    output logic [5:0]       hash_idx
);

    localparam int STEPS      = ADDR_BITS / STEP_BITS;
    localparam int STEP_CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [2:0]            LAST_BYTE = 3'(ADDR_BYTES - 1);
    localparam logic [STEP_CNT_W-1:0] LAST_STEP = STEP_CNT_W'(STEPS - 1);

    filt_state_t state_q, state_d;

    logic [2:0]               byte_cnt_q;
    logic [ADDR_BITS-1:0]     addr_q;
    logic [ADDR_BITS-1:0]     sh_q;
    logic [STEP_CNT_W-1:0]    step_cnt_q;
    logic                     end_seen_q;
    logic                     short_q;
    logic                     crc_ok_q;
    logic [LEN_W-1:0]         len_q;

    logic [TABLE_ENTRIES-1:0] hash_tbl;
    logic [ADDR_BITS-1:0]     station;
    filt_en_t                 en;
    logic [LEN_W-1:0]         max_len;
    logic [HASH_W-1:0]        idx;
    logic                     accept_raw;
    logic                     last_byte_in;

    rxf_cfg_regs #(.LEN_W(LEN_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .hash_tbl (hash_tbl),
        .station  (station),
        .en       (en),
        .max_len  (max_len)
    );

    rxf_hash_crc #(.STEP_BITS(STEP_BITS)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .preset  (state_q == ST_ADDR),
        .advance (state_q == ST_HASH),
        .din     (sh_q[STEP_BITS-1:0]),
        .idx     (idx)
    );

    rxf_verdict #(.LEN_W(LEN_W)) u_verdict (
        .dst        (addr_q),
        .station    (station),
        .hash_tbl   (hash_tbl),
        .idx        (idx),
        .en         (en),
        .len        (len_q),
        .max_len    (max_len),
        .crc_ok     (crc_ok_q),
        .short_addr (short_q),
        .accept     (accept_raw)
    );

    assign last_byte_in = byte_valid && (byte_cnt_q == LAST_BYTE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (frm_start) state_d = ST_ADDR;
            ST_ADDR: begin
                if (last_byte_in)  state_d = ST_HASH;
                else if (frm_end)  state_d = ST_VERDICT;
            end
            ST_HASH:    if (step_cnt_q == LAST_STEP) state_d = ST_WAIT;
            ST_WAIT:    if (end_seen_q || frm_end) state_d = ST_VERDICT;
            ST_VERDICT: state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt_q <= '0;
            addr_q     <= '0;
            sh_q       <= '0;
            step_cnt_q <= '0;
            end_seen_q <= 1'b0;
            short_q    <= 1'b0;
            crc_ok_q   <= 1'b0;
            len_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (frm_start) begin
                        byte_cnt_q <= '0;
                        end_seen_q <= 1'b0;
                        short_q    <= 1'b0;
                    end
                end
                ST_ADDR: begin
                    if (byte_valid) begin
                        addr_q[{byte_cnt_q, 3'b000} +: 8] <= byte_data;
                        byte_cnt_q <= byte_cnt_q + 3'd1;
                    end
                    if (last_byte_in) begin
                        sh_q       <= {byte_data, addr_q[ADDR_BITS-9:0]};
                        step_cnt_q <= '0;
                    end else if (frm_end) begin
                        short_q <= 1'b1;
                    end
                end
                ST_HASH: begin
                    sh_q       <= sh_q >> STEP_BITS;
                    step_cnt_q <= step_cnt_q + 1'b1;
                end
                default: ;
            endcase
            if (frm_end && !end_seen_q &&
                (state_q inside {ST_ADDR, ST_HASH, ST_WAIT})) begin
                end_seen_q <= 1'b1;
                len_q      <= frm_len;
                crc_ok_q   <= frm_crc_ok;
            end
        end
    end

    // outputs
    always_comb begin
        verdict_valid  = (state_q == ST_VERDICT);
        verdict_accept = verdict_valid && accept_raw;
        hash_idx       = idx;
    end

endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             verdict_valid,
    input logic             verdict_accept,
    input logic [LEN_W-1:0] len_q,
    input logic [LEN_W-1:0] max_len,
    input logic             crc_ok_q,
    input logic             crc_req,
    input logic             runt_rej,
    input logic             short_q
);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R10
    accept_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_accept |-> verdict_valid);

    // R10
    short_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && short_q) |-> !verdict_accept);

    // R9
    too_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && (len_q > max_len)) |-> !verdict_accept);

    // R8
    runt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && runt_rej && (len_q < LEN_W'(64))) |-> !verdict_accept);

    // R7
    crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && crc_req && !crc_ok_q) |-> !verdict_accept);

endmodule

bind rx_addr_filter rxf_filter_chk #(.LEN_W(LEN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept),
    .len_q          (len_q),
    .max_len        (max_len),
    .crc_ok_q       (crc_ok_q),
    .crc_req        (en.crc_req),
    .runt_rej       (en.runt_rej),
    .short_q        (short_q)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;

    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_sel = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             frm_start = 1'b0;
    logic             byte_valid = 1'b0;
    logic [7:0]       byte_data = '0;
    logic             frm_end = 1'b0;
    logic [LEN_W-1:0] frm_len = '0;
    logic             frm_crc_ok = 1'b0;
    logic             verdict_valid;
    logic             verdict_accept;
    logic [5:0]       hash_idx;

    always #4 clk = ~clk;

    rx_addr_filter dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_wdata      (cfg_wdata),
        .frm_start      (frm_start),
        .byte_valid     (byte_valid),
        .byte_data      (byte_data),
        .frm_end        (frm_end),
        .frm_len        (frm_len),
        .frm_crc_ok     (frm_crc_ok),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept),
        .hash_idx       (hash_idx)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] cur_ht  = '0;
    logic [47:0] cur_st  = '0;
    logic [4:0]  cur_en  = '0;
    int          cur_max = 1518;

    task automatic check_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            fb = c[31] ^ a[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c[28:23];
    endfunction

    function automatic bit ref_accept(input logic [47:0] a, input int len, input bit ok);
        bit m;
        m = (cur_en[1] && a == cur_st) || (cur_en[2] && a == 48'hFFFF_FFFF_FFFF) ||
            (cur_en[0] && cur_ht[ref_idx(a)]);
        if (cur_en[3] && !ok) m = 1'b0;
        if (cur_en[4] && len < 64) m = 1'b0;
        if (len > cur_max) m = 1'b0;
        return m;
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ht(input logic [63:0] v);
        wr(3'd0, v[31:0]); wr(3'd1, v[63:32]); cur_ht = v;
    endtask

    task automatic set_st(input logic [47:0] v);
        wr(3'd2, {16'h0, v[15:0]}); wr(3'd3, {16'h0, v[31:16]}); wr(3'd4, {16'h0, v[47:32]});
        cur_st = v;
    endtask

    task automatic set_en(input logic [4:0] v);
        wr(3'd5, {27'h0, v}); cur_en = v;
    endtask

    task automatic set_max(input int v);
        wr(3'd6, 32'(v)); cur_max = v;
    endtask

    task automatic run_frame(input logic [47:0] a, input int nbytes, input int len, input bit ok,
                             output bit got, output bit acc, output logic [5:0] idx);
        got = 1'b0; acc = 1'b0; idx = '0;
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
        for (int b = 0; b < nbytes; b++) begin
            byte_valid = 1'b1; byte_data = a[8*b +: 8];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        frm_end = 1'b1; frm_len = LEN_W'(len); frm_crc_ok = ok;
        @(negedge clk);
        frm_end = 1'b0;
        for (int t = 0; t < 200 && !got; t++) begin
            if (verdict_valid) begin
                got = 1'b1; acc = verdict_accept; idx = hash_idx;
            end else begin
                if (verdict_accept) check_eq("R10 accept without valid", 1, 0);
                @(negedge clk);
            end
        end
        check_eq("R10 verdict pulse present", got, 1);
        if (got) begin
            @(negedge clk);
            check_eq("R10 verdict pulse one cycle", verdict_valid, 0);
        end
    endtask

    task automatic frame_expect(input string tag, input logic [47:0] a, input int len, input bit ok);
        bit got, acc;
        logic [5:0] idx;
        run_frame(a, 6, len, ok, got, acc, idx);
        check_eq(tag, acc, ref_accept(a, len, ok));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] bcast;
        logic [47:0] mc;
        logic [47:0] miss;
        logic [47:0] kinds [4];
        logic [63:0] s;
        bit [63:0]   seen;
        int          nseen;
        bit          got, acc;
        logic [5:0]  idx;
        int          lens [3];

        bcast = 48'hFFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_eq("R1 verdict_valid after reset", verdict_valid, 0);
        frame_expect("R1 all enables off rejects broadcast", bcast, 100, 1'b1);
        check_eq("R1 model says reject", ref_accept(bcast, 100, 1'b1), 0);
        set_en(5'b00001);
        frame_expect("R1 empty hash table rejects", 48'h0000_5E00_0001, 100, 1'b1);
        set_en(5'b00100);
        frame_expect("R1 R9 default max 1518 accepted", bcast, 1518, 1'b1);
        frame_expect("R1 R9 default max 1519 rejected", bcast, 1519, 1'b1);

        // R9: programmed maximum
        set_max(200);
        frame_expect("R9 length equal to max", bcast, 200, 1'b1);
        frame_expect("R9 length above max", bcast, 201, 1'b1);
        set_max(1518);

        // R10: early end before six bytes
        run_frame(bcast, 3, 100, 1'b1, got, acc, idx);
        check_eq("R10 short address rejected", acc, 0);

        // R3 R4: hash sweep over every table entry
        set_en(5'b00001);
        s = 64'h1234_5678_9ABC_DEF1;
        seen = '0; nseen = 0;
        for (int n = 0; n < 4000 && nseen < 64; n++) begin
            logic [47:0] a;
            logic [5:0]  k;
            s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
            a = s[63:16];
            a[0] = 1'b1;
            k = ref_idx(a);
            if (!seen[k]) begin
                seen[k] = 1'b1; nseen++;
                set_ht(64'd1 << k);
                run_frame(a, 6, 100, 1'b1, got, acc, idx);
                check_eq("R3 hash index", idx, k);
                check_eq("R4 single entry set accepts", acc, 1);
                set_ht(~(64'd1 << k));
                run_frame(a, 6, 100, 1'b1, got, acc, idx);
                check_eq("R4 own entry clear rejects", acc, 0);
            end
        end
        check_eq("R3 all 64 indices reached", nseen, 64);

        // R2 R5 R6 R7 R8: enable sweep
        set_st(48'h025E_4D3C_2B1A);
        mc = 48'h0300_005E_0001;
        set_ht(64'd1 << ref_idx(mc));
        miss = 48'h0000_0000_7702;
        while (ref_idx(miss) == ref_idx(mc)) miss = miss + 48'h100;
        kinds[0] = cur_st; kinds[1] = bcast; kinds[2] = mc; kinds[3] = miss;
        lens[0] = 63; lens[1] = 64; lens[2] = 1600;
        for (int e = 0; e < 32; e++) begin
            set_en(5'(e));
            for (int kd = 0; kd < 4; kd++)
                for (int c = 0; c < 2; c++)
                    for (int li = 0; li < 3; li++)
                        frame_expect("R2 R5 R6 R7 R8 R9 enable sweep",
                                     kinds[kd], lens[li], c[0]);
        end

        // R2: select 7 is ignored (broadcast enable stays, no disruption)
        set_en(5'b00100);
        wr(3'd7, 32'h0);
        frame_expect("R2 select 7 ignored", bcast, 100, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule